// File: doc/BRIEF.md
# Streaming 3x3 Median Filter

This block takes a raster stream of 8-bit pixels and produces the median of each 3x3 neighbourhood. It serves as the robust noise-strength estimator in a wavelet denoising datapath. Two internal line stores keep the two rows above the current one. Each accepted pixel therefore forms a fresh three-pixel column. A three-input sort cell orders that column, and the result is held with the two sorted columns before it. Two further compare stages then drop the outermost candidates until a single median is left. In the first of these stages the largest of the column minima, the middle of the column medians and the smallest of the column maxima survive. The second stage takes the middle of those three.

Both sides use valid/ready handshakes. A pixel transfers on a rising edge where `in_valid` and `in_ready` are both high, and a median transfers where `out_valid` and `out_ready` are both high. While a median waits unaccepted, the whole pipeline freezes and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Windows that would reach past the top or left image border are not produced; no border replication is done.

Top module: `med3x3_stream`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Every produced `out_median` equals the median (the 5th smallest, unsigned) of the nine pixels at columns x-2..x of the current line and of the same columns in the two preceding lines.
- R3: A median is produced only for an accepted pixel at column index 2 or more in a line that has at least two complete lines before it since reset. This gives (rows-2)*(width-2) medians per image, in raster order, and none for lines shorter than 3 pixels.
- R4: Without back-pressure, the median for a window appears with `out_valid` high right after the third rising edge, counting the edge that accepts the window's last pixel as the first.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_median` hold their values into the next cycle.
- R6: An accepted pixel with `in_line_start` = 1 sits at column 0 and starts a new line, even in mid-line. Line stores keep, for each column, the last two pixels accepted at that column, so a short line leaves older data in the columns it did not reach.
- R7: Pixels accepted after reset and before the first pixel flagged with `in_line_start` are discarded and contribute to no median.
- R8: Cycles with `in_valid` low leave the window state unchanged; the median sequence is the same as for a gap-free stream.
- R9: Lines of up to `LINE_W` pixels are supported; the column index wraps to 0 after `LINE_W` pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block can accept a pixel this cycle |
| in_pixel | input | 8 | Input pixel, unsigned |
| in_line_start | input | 1 | Marks the first pixel of a line |
| out_valid | output | 1 | Median output is valid |
| out_ready | input | 1 | Downstream accepts the median |
| out_median | output | 8 | Median of the 3x3 window, unsigned |

## Verification
Corrupt line-store or presorted-column state shows up as wrong medians at the first window that reads the bad column, so the fault is visible three edges after the offending pixel is accepted. A wrong column index or line count shows up as medians that are missing, extra or shifted in the sequence at the start of the first full line. Stall faults show up as a median that changes or vanishes while `out_ready` is low, or as a pixel taken while the output is blocked; the comparison of the whole median sequence under random back-pressure exposes them within a few rows.

// File: rtl/med3_pkg.sv
package med3_pkg;
  localparam int PIX_W = 8;
  localparam int WIN   = 3;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t hi;
    pix_t mid;
    pix_t lo;
  } col_t;

  function automatic pix_t min3(input pix_t a, input pix_t b, input pix_t c);
    pix_t m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic pix_t max3(input pix_t a, input pix_t b, input pix_t c);
    pix_t m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic pix_t med3(input pix_t a, input pix_t b, input pix_t c);
    pix_t lo_ab;
    pix_t hi_ab;
    lo_ab = (a < b) ? a : b;
    hi_ab = (a < b) ? b : a;
    if (c > hi_ab)      return hi_ab;
    else if (c < lo_ab) return lo_ab;
    else                return c;
  endfunction
endpackage

// File: rtl/med3_sort3.sv
module med3_sort3
  import med3_pkg::*;
(
  input  pix_t a,
  input  pix_t b,
  input  pix_t c,
  output col_t srt
);
  always_comb begin
    srt.lo  = min3(a, b, c);
    srt.mid = med3(a, b, c);
    srt.hi  = max3(a, b, c);
  end
endmodule

// File: rtl/med3_line_store.sv
module med3_line_store
  import med3_pkg::*;
#(
  parameter  int LINE_W = 512,
  localparam int AW     = $clog2(LINE_W),
  localparam int TAPS   = WIN - 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  pix_t              din,
  output pix_t [TAPS-1:0]   taps
);
  // feed[0] is the incoming pixel, feed[t+1] the pixel t+1 lines up
  pix_t [TAPS:0] feed;
  assign feed[0] = din;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    pix_t row [LINE_W];
    always_ff @(posedge clk) begin
      if (wr_en) row[addr] <= feed[t];
    end
    assign feed[t+1] = row[addr];
    assign taps[t]   = feed[t+1];
  end
endmodule

// File: rtl/med3_tracker.sv
module med3_tracker
  import med3_pkg::*;
#(
  parameter  int LINE_W = 512,
  localparam int AW     = $clog2(LINE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          sol,
  output logic          take,
  output logic [AW-1:0] x,
  output logic          win_ok,
  output logic          started,
  output logic          rows_full
);
  localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);
  localparam logic [AW-1:0] MINX = AW'(WIN - 1);
  localparam logic [1:0]    FULL = 2'(WIN - 1);

  logic [AW-1:0] col_idx;
  logic [1:0]    lines;

  always_comb begin
    take      = fire && (started || sol);
    x         = sol ? '0 : col_idx;
    rows_full = (lines == FULL);
    win_ok    = rows_full && (x >= MINX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_idx <= '0;
      lines   <= '0;
      started <= 1'b0;
    end else if (take) begin
      started <= 1'b1;
      col_idx <= (x == LAST) ? '0 : x + 1'b1;
      if (sol && started && !rows_full) lines <= lines + 1'b1;
    end
  end
endmodule

// File: rtl/med3_core.sv
module med3_core
  import med3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  input  logic win_ok,
  input  pix_t px_new,
  input  pix_t up1,
  input  pix_t up2,
  output pix_t median,
  output logic out_vld
);
  col_t             fresh;
  col_t [WIN-1:0]   win_q;
  pix_t             s_lo, s_mid, s_hi;
  logic             v1, v2;

  med3_sort3 u_col (.a(up2), .b(up1), .c(px_new), .srt(fresh));

  // stage 1: presorted column shift register, advances per accepted pixel
  always_ff @(posedge clk) begin
    if (take) win_q <= {win_q[WIN-2:0], fresh};
  end

  // stages 2 and 3: discard outer candidates
  always_ff @(posedge clk) begin
    if (en) begin
      s_lo   <= max3(win_q[0].lo,  win_q[1].lo,  win_q[2].lo);
      s_mid  <= med3(win_q[0].mid, win_q[1].mid, win_q[2].mid);
      s_hi   <= min3(win_q[0].hi,  win_q[1].hi,  win_q[2].hi);
      median <= med3(s_lo, s_mid, s_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      out_vld <= 1'b0;
    end else if (en) begin
      v1      <= take && win_ok;
      v2      <= v1;
      out_vld <= v2;
    end
  end
endmodule

// File: rtl/med3x3_stream.sv
module med3x3_stream
  import med3_pkg::*;
#(
  parameter  int LINE_W = 512,
  localparam int AW     = $clog2(LINE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_line_start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_median
);
  logic              en;
  logic              trk_take;
  logic [AW-1:0]     trk_x;
  logic              trk_win_ok;
  logic              trk_started;
  logic              trk_rows_full;
  pix_t [WIN-2:0]    taps;
  pix_t              med_q;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  med3_tracker #(.LINE_W(LINE_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (in_valid && en),
    .sol      (in_line_start),
    .take     (trk_take),
    .x        (trk_x),
    .win_ok   (trk_win_ok),
    .started  (trk_started),
    .rows_full(trk_rows_full)
  );

  med3_line_store #(.LINE_W(LINE_W)) u_lines (
    .clk  (clk),
    .wr_en(trk_take),
    .addr (trk_x),
    .din  (in_pixel),
    .taps (taps)
  );

  med3_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .take   (trk_take),
    .win_ok (trk_win_ok),
    .px_new (in_pixel),
    .up1    (taps[0]),
    .up2    (taps[1]),
    .median (med_q),
    .out_vld(out_valid)
  );

  assign out_median = med_q;
endmodule

// File: rtl/med3_checker.sv
module med3_checker
  import med3_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input pix_t out_median,
  input logic started,
  input logic rows_full
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_median));

  p_block_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_no_out_before_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !out_valid);

  p_two_lines_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rows_full);
endmodule

bind med3x3_stream med3_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_median(out_median),
  .started   (trk_started),
  .rows_full (trk_rows_full)
);

// File: tb/med3x3_stream_bench.sv
`timescale 1ns/100ps
module med3x3_stream_bench;
  localparam int TB_LINE = 8;
  localparam int TW = 6;
  localparam logic [7:0] TAB_PIX [0:23] = '{
    8'd10, 8'd200, 8'd30,  8'd40, 8'd50,  8'd60,
    8'd15, 8'd25,  8'd255, 8'd35, 8'd0,   8'd45,
    8'd20, 8'd90,  8'd5,   8'd70, 8'd80,  8'd100,
    8'd12, 8'd14,  8'd16,  8'd18, 8'd250, 8'd22};
  localparam logic [7:0] TAB_EXP [0:7] = '{
    8'd25, 8'd40, 8'd40, 8'd50, 8'd16, 8'd25, 8'd35, 8'd45};

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [7:0] in_pixel = 0;
  logic       in_line_start = 0;
  logic       out_valid;
  logic       out_ready = 1;
  logic [7:0] out_median;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_med [0:255];
  int exp_cyc [0:255];
  int got_med [0:255];
  int got_cyc [0:255];
  int n_exp = 0, n_got = 0;
  int h1 [0:TB_LINE-1];
  int h2 [0:TB_LINE-1];
  int mw [0:2][0:2];
  int m_col = 0, m_lines = 0;
  bit m_started = 0;
  bit stall_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 0;
  logic [7:0] prev_med = 0;
  int hold_chk = 0, hold_bad = 0, ready_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  med3x3_stream #(.LINE_W(TB_LINE)) u_med3x3_stream (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_line_start(in_line_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_median(out_median));

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int median9(input int v [0:8]);
    int s [0:8];
    int t;
    s = v;
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    return s[4];
  endfunction

  task automatic model_take(input int p, input bit s, input int c);
    int x;
    int w [0:8];
    if (!m_started && !s) return;
    x = s ? 0 : m_col;
    if (s && m_started && m_lines < 2) m_lines++;
    m_started = 1;
    for (int r = 0; r < 3; r++) begin
      mw[2][r] = mw[1][r];
      mw[1][r] = mw[0][r];
    end
    mw[0][0] = h2[x]; mw[0][1] = h1[x]; mw[0][2] = p;
    if (m_lines == 2 && x >= 2) begin
      for (int a = 0; a < 3; a++)
        for (int r = 0; r < 3; r++) w[a*3+r] = mw[a][r];
      exp_med[n_exp] = median9(w);
      exp_cyc[n_exp] = c + 3;
      n_exp++;
    end
    h2[x] = h1[x];
    h1[x] = p;
    m_col = (x == TB_LINE - 1) ? 0 : x + 1;
  endtask

  task automatic send_px(input int p, input bit s);
    in_valid = 1; in_pixel = 8'(p); in_line_start = s;
    do @(negedge clk); while (!in_ready);
    model_take(p, s, cyc);
    @(posedge clk); #1;
    in_valid = 0; in_line_start = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 0;
    n_exp = 0; n_got = 0; m_col = 0; m_lines = 0; m_started = 0;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic compare_all(input string req);
    stall_on = 0;
    idle(12);
    chk({req, " median count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk({req, " median value"}, got_med[i], exp_med[i]);
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (stall_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] & lfsr[2];
    end else out_ready = 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        hold_chk++;
        if (!out_valid || out_median != prev_med) hold_bad++;
      end
      if (out_valid && !out_ready && in_ready) ready_bad++;
      if (out_valid && out_ready) begin
        got_med[n_got] = out_median; got_cyc[n_got] = cyc; n_got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_med = out_median;
    end else prev_stall = 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 1);
    rst_n = 1;
    idle(1);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);

    // table walk: 4 lines of 6, no gaps, no back-pressure
    for (int i = 0; i < 24; i++) send_px(TAB_PIX[i], (i % TW) == 0);
    idle(8);
    chk("R3 table median count", n_got, 8);
    for (int i = 0; i < 8 && i < n_got; i++)
      chk("R2 table median", got_med[i], TAB_EXP[i]);
    for (int i = 0; i < 8 && i < n_got; i++)
      chk("R4 latency cycle", got_cyc[i], exp_cyc[i]);

    // full-width lines, gaps and random back-pressure (R5, R8, R9)
    do_reset();
    stall_on = 1;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < TB_LINE; c++) begin
        send_px((r*37 + c*91 + r*c*13) % 256, c == 0);
        if ((r*TB_LINE + c) % 5 == 4) idle(2);
      end
    compare_all("R5 R8 R9 stalled stream");
    chk("R9 count for full lines", n_got, 3*(TB_LINE-2));
    chk("R5 stall cycles seen", hold_chk > 0, 1);
    chk("R5 output held while stalled", hold_bad, 0);
    chk("R5 in_ready low while stalled", ready_bad, 0);

    // extremes: checkerboard and flat rows
    do_reset();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 5; c++)
        send_px((r == 3) ? 128 : (((r + c) % 2) ? 255 : 0), c == 0);
    compare_all("R2 extreme values");

    // pixels before the first line start are dropped (R7)
    do_reset();
    for (int i = 0; i < 4; i++) send_px(200 + i, 0);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) send_px(r*3 + c + 1, c == 0);
    idle(8);
    chk("R7 single median after dropped pixels", n_got, 1);
    if (n_got > 0) chk("R7 median ignores early pixels", got_med[0], 5);

    // mid-line restarts and short lines (R6, R3)
    do_reset();
    begin
      int widths [0:4] = '{5, 5, 3, 2, 5};
      for (int l = 0; l < 5; l++)
        for (int c = 0; c < widths[l]; c++) send_px((l*53 + c*29 + 7) % 256, c == 0);
    end
    compare_all("R6 short lines");
    chk("R3 medians for short lines", n_got, 4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule